// File: doc/BRIEF.md
# Extended Mode Register 2 Capture and Decode

This block sits on the device side of a DDR2-style SDRAM command interface and watches for writes aimed at the second extended mode register. A mode register command is recognised when chip select, RAS, CAS and WE are all sampled low on a rising clock edge. The block updates only when the bank-address bits carry the code 3'b010 and the write is legal. A legal write needs CKE high, every bank idle, and no earlier write still inside its settle window. The block then stores the high-temperature self-refresh bit (address bit 7) and the partial-array self-refresh code (address bits 2:0).

From the stored fields it drives two outputs. The first is the high-temperature self-refresh enable. The second is an 8-bit mask that lists the banks which keep their contents under partial-array self refresh. The mask is asymmetric: codes 3'b000 to 3'b011 keep banks counted up from bank 0, and codes 3'b100 to 3'b111 keep banks counted down from bank 7.

After each accepted write, a busy flag covers the mode-register delay, which is a parameter counted in clocks. The block raises a sticky error flag for any of these cases:
- a write made at the wrong time;
- a mode register command that arrives while busy;
- a write with nonzero reserved bits.

Reset does not touch the stored fields. A valid flag marks when the fields have been written at least once.

Top module: `xmr2_ctrl`

## Requirements
- R1: Only a command with cs_n, ras_n, cas_n and we_n all low and ba equal to 3'b010 can update the register; the same command with any other ba code changes no output and sets no error.
- R2: After an accepted write, hot_sr_en equals address bit 7 of that write.
- R3: After an accepted write, ret_banks decodes address bits 2:0 (code c) as follows, where bit i stands for bank i:

  | c | ret_banks |
  |---|-----------|
  | 0 | 8'hFF |
  | 1 | 8'h0F |
  | 2 | 8'h03 |
  | 3 | 8'h01 |
  | 4 | 8'hFC |
  | 5 | 8'hF0 |
  | 6 | 8'hC0 |
  | 7 | 8'h80 |

- R4: A write to ba 3'b010 while any bit of bank_idle is 0 or cke is 0 leaves hot_sr_en and ret_banks unchanged and sets err.
- R5: After an accepted write at clock edge k, busy is high for exactly TMRD clock cycles. A mode register command (any ba) sampled at edges k+1 to k+TMRD is ignored and sets err. A write at edge k+TMRD+1 is accepted.
- R6: A write with any of address bits 3 to 6 or 8 to 12 set still stores bit 7 and bits 2:0 and sets valid, but also sets err.
- R7: Reset clears valid, busy and err but leaves hot_sr_en and ret_banks at their last written values.
- R8: valid is 0 from reset until the first accepted write and stays 1 afterwards.
- R9: err, once set, stays set through later accepted writes until reset.
- R10: A command with any of cs_n, ras_n, cas_n or we_n high changes no output and sets no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, is released through a two-stage synchronizer |
| cke | input | 1 | Clock enable from the controller; must be high for a write |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address; selects the target mode register |
| addr | input | 13 | Address bus carrying the register value |
| bank_idle | input | 8 | One bit per bank, 1 when that bank is precharged and idle |
| hot_sr_en | output | 1 | Stored high-temperature self-refresh enable |
| ret_banks | output | 8 | Banks kept under partial-array self refresh, bit i stands for bank i |
| valid | output | 1 | Register written at least once since reset |
| busy | output | 1 | Mode-register delay running after an accepted write |
| err | output | 1 | Sticky error flag for illegal commands |

## Verification
The decode function is swept over all eight self-refresh codes with both values of bit 7. This distinguishes lower-half from upper-half masks and shows that bit 7 is independent of the code. The command pins are tried in all fifteen non-command combinations, and the bank address in all seven non-target codes. These sweeps separate a correct command decode from one that ignores a pin or a bank bit. Legality is probed by lowering each bank_idle bit in turn and then cke. A second write is placed at each distance from 1 to TMRD+1 cycles, which pins down the exact end of the busy window. Each reserved address bit is set alone, which shows that the legal fields are stored while the error still rises.

// File: rtl/xmr2_pkg.sv
package xmr2_pkg;
  localparam int BA_W     = 3;
  localparam int ADDR_W   = 13;
  localparam int NBANK    = 2 ** BA_W;
  localparam int HOT_BIT  = 7;
  localparam int CODE_W   = 3;
  localparam logic [BA_W-1:0] TARGET_BA = BA_W'(2);

  typedef struct packed {
    logic              hot;
    logic [CODE_W-1:0] code;
  } xmr2_fields_t;
endpackage

// File: rtl/xmr2_cmd_decode.sv
module xmr2_cmd_decode
  import xmr2_pkg::*;
(
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bank_idle,
  input  logic              busy,
  output logic              is_mrs,
  output logic              hit,
  output logic              accept,
  output logic              set_err,
  output xmr2_fields_t      fields_in
);
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    (ADDR_W'(1) << HOT_BIT) | ADDR_W'((1 << CODE_W) - 1);

  logic all_idle;
  logic legal_state;
  logic rsvd_bad;
  logic late_reject;
  logic busy_reject;

  always_comb begin
    is_mrs      = ~cs_n & ~ras_n & ~cas_n & ~we_n;
    hit         = is_mrs & (ba == TARGET_BA);
    all_idle    = &bank_idle;
    legal_state = cke & all_idle;
    rsvd_bad    = |(addr & ~KEEP_MASK);
    busy_reject = is_mrs & busy;
    late_reject = hit & ~busy & ~legal_state;
    accept      = hit & ~busy & legal_state;
    set_err     = busy_reject | late_reject | (accept & rsvd_bad);
    fields_in.hot  = addr[HOT_BIT];
    fields_in.code = addr[CODE_W-1:0];
  end
endmodule

// File: rtl/xmr2_hold_timer.sv
module xmr2_hold_timer #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = (TMRD < 1) ? 1 : $clog2(TMRD + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TMRD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  // R5: the window shrinks by one each cycle when it is not reloaded
  a_r5_count_down: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5: no new load can arrive while the window runs
  a_r5_no_reload_busy: assert property (@(posedge clk) disable iff (!arst_n)
    busy |-> !load);
endmodule

// File: rtl/xmr2_pasr_mask.sv
module xmr2_pasr_mask
  import xmr2_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [NBANK-1:0]  mask
);
  localparam int NW = BA_W + 1;
  localparam logic [NW-1:0] ALL  = NW'(NBANK);
  localparam logic [NW-1:0] WIDE = NW'(NBANK - NBANK / 4);

  logic [NW-1:0] n_low;
  logic [NW-1:0] n_high;
  logic [NW-1:0] high_floor;

  always_comb begin
    n_low      = ALL >> code[1:0];
    n_high     = (code[1:0] == 2'd0) ? WIDE : n_low;
    high_floor = ALL - n_high;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign mask[b] = code[2] ? (NW'(b) >= high_floor) : (NW'(b) < n_low);
  end
endmodule

// File: rtl/xmr2_store.sv
module xmr2_store
  import xmr2_pkg::*;
(
  input  logic         clk,
  input  logic         arst_n,
  input  logic         accept,
  input  logic         set_err,
  input  xmr2_fields_t fields_in,
  output xmr2_fields_t fields,
  output logic         valid,
  output logic         err
);
  xmr2_fields_t fld_q;
  xmr2_fields_t fld_d;
  logic         valid_q;
  logic         valid_d;
  logic         err_q;
  logic         err_d;

  always_comb begin
    fld_d   = accept ? fields_in : fld_q;
    valid_d = valid_q | accept;
    err_d   = err_q | set_err;
  end

  // contents have no reset value
  always_ff @(posedge clk) begin
    fld_q <= fld_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign fields = fld_q;
  assign valid  = valid_q;
  assign err    = err_q;

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    valid |=> valid);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    err |=> err);

  a_r2_hot_captured: assert property (@(posedge clk) disable iff (!arst_n)
    accept |=> (fields.hot == $past(fields_in.hot)));
endmodule

// File: rtl/xmr2_ctrl.sv
module xmr2_ctrl
  import xmr2_pkg::*;
#(
  parameter int TMRD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bank_idle,
  output logic              hot_sr_en,
  output logic [NBANK-1:0]  ret_banks,
  output logic              valid,
  output logic              busy,
  output logic              err
);
  logic [1:0]   rst_sync_q;
  logic         arst_n;
  logic         is_mrs;
  logic         hit;
  logic         accept;
  logic         set_err;
  logic         busy_w;
  xmr2_fields_t fields_in;
  xmr2_fields_t fields;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign arst_n = rst_sync_q[1];

  xmr2_cmd_decode u_dec (
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .bank_idle (bank_idle),
    .busy      (busy_w),
    .is_mrs    (is_mrs),
    .hit       (hit),
    .accept    (accept),
    .set_err   (set_err),
    .fields_in (fields_in)
  );

  xmr2_hold_timer #(.TMRD(TMRD)) u_tmr (
    .clk    (clk),
    .arst_n (arst_n),
    .load   (accept),
    .busy   (busy_w)
  );

  xmr2_store u_store (
    .clk       (clk),
    .arst_n    (arst_n),
    .accept    (accept),
    .set_err   (set_err),
    .fields_in (fields_in),
    .fields    (fields),
    .valid     (valid),
    .err       (err)
  );

  xmr2_pasr_mask u_mask (
    .code (fields.code),
    .mask (ret_banks)
  );

  assign hot_sr_en = fields.hot;
  assign busy      = busy_w;

  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!arst_n)
    accept |=> busy);

  a_r5_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!arst_n)
    (is_mrs && busy) |=> (err && $stable(hot_sr_en) && $stable(ret_banks)));

  a_r4_bad_state_rejected: assert property (@(posedge clk) disable iff (!arst_n)
    (hit && !busy && !(cke && (&bank_idle))) |=>
      (err && $stable(hot_sr_en) && $stable(ret_banks)));

  a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (!arst_n)
    valid |-> (ret_banks != '0));
endmodule

// File: tb/test_xmr2_ctrl.sv
`timescale 1ns/1ps
module test_xmr2_ctrl;
  localparam int TMRD = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [12:0] addr;
  logic [7:0]  bank_idle;
  logic        hot_sr_en;
  logic [7:0]  ret_banks;
  logic        valid, busy, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xmr2_ctrl #(.TMRD(TMRD)) i_xmr2_ctrl (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_idle(bank_idle),
    .hot_sr_en(hot_sr_en), .ret_banks(ret_banks), .valid(valid),
    .busy(busy), .err(err)
  );

  function automatic logic [7:0] exp_mask(input int c);
    int n;
    if (c < 4) begin
      n = 8 >> c;
      return 8'((1 << n) - 1);
    end
    n = (c == 4) ? 6 : (8 >> (c - 4));
    return 8'(~((1 << (8 - n)) - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nop();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    nop();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // called at a negedge; command is sampled at the next posedge
  task automatic do_cmd(input logic [3:0] pins, input logic [2:0] b,
                        input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = b;
    addr = a;
    @(negedge clk);
    nop();
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] m_keep;
    logic       h_keep;
    rst_n = 1'b1; cke = 1'b1; bank_idle = 8'hFF; ba = 3'd0; addr = '0;
    nop();
    do_reset();

    // R7 / R8: reset state
    chk(valid == 1'b0, "R8 valid after reset", 16'(valid), 0);
    chk(busy == 1'b0, "R7 busy after reset", 16'(busy), 0);
    chk(err == 1'b0, "R7 err after reset", 16'(err), 0);

    // R10: all non-command pin patterns
    for (int p = 1; p < 16; p++) begin
      do_cmd(4'(p), 3'd2, 13'h0081);
      chk(!valid && !busy && !err, "R10 non-command ignored",
          16'({valid, busy, err}), 0);
    end

    // R1: other register codes
    for (int b = 0; b < 8; b++) begin
      if (b == 2) continue;
      do_cmd(4'b0000, 3'(b), 13'h0081);
      chk(!valid && !busy && !err, "R1 other ba ignored",
          16'({valid, busy, err}), 0);
    end

    // R2 / R3 / R5 / R8: full sweep
    for (int h = 0; h < 2; h++) begin
      for (int c = 0; c < 8; c++) begin
        int n;
        do_cmd(4'b0000, 3'd2, 13'((h << 7) | c));
        chk(valid == 1'b1, "R8 valid after write", 16'(valid), 1);
        chk(hot_sr_en == 1'(h), "R2 hot bit", 16'(hot_sr_en), 16'(h));
        chk(ret_banks == exp_mask(c), "R3 bank mask", 16'(ret_banks),
            16'(exp_mask(c)));
        chk(err == 1'b0, "R6 clean write no err", 16'(err), 0);
        n = 0;
        while (busy && n < 20) begin
          n++;
          @(negedge clk);
        end
        chk(n == TMRD, "R5 busy length", 16'(n), 16'(TMRD));
      end
    end

    // R5: second write at each distance
    for (int j = 1; j <= TMRD + 1; j++) begin
      do_reset();
      do_cmd(4'b0000, 3'd2, 13'h0003);
      repeat (j - 1) @(negedge clk);
      do_cmd(4'b0000, 3'd2, 13'h0086);
      if (j <= TMRD) begin
        chk(err == 1'b1, "R5 write while busy err", 16'(err), 1);
        chk(ret_banks == 8'h01 && !hot_sr_en, "R5 write while busy ignored",
            16'({hot_sr_en, ret_banks}), 16'h0001);
      end else begin
        chk(err == 1'b0, "R5 write after window no err", 16'(err), 0);
        chk(ret_banks == 8'hC0 && hot_sr_en, "R5 write after window taken",
            16'({hot_sr_en, ret_banks}), 16'h01C0);
      end
      wait_idle();
    end

    // R5: other register command while busy
    do_reset();
    do_cmd(4'b0000, 3'd2, 13'h0001);
    do_cmd(4'b0000, 3'd0, 13'h0000);
    chk(err == 1'b1, "R5 other ba while busy err", 16'(err), 1);
    wait_idle();

    // R4: each bank active, then cke low
    for (int b = 0; b < 9; b++) begin
      do_reset();
      do_cmd(4'b0000, 3'd2, 13'h0005);
      wait_idle();
      if (b < 8) bank_idle = ~(8'(1) << b);
      else cke = 1'b0;
      do_cmd(4'b0000, 3'd2, 13'h0082);
      bank_idle = 8'hFF;
      cke = 1'b1;
      chk(err == 1'b1, "R4 illegal state err", 16'(err), 1);
      chk(ret_banks == 8'hF0 && !hot_sr_en && !busy, "R4 illegal state ignored",
          16'({busy, hot_sr_en, ret_banks}), 16'h00F0);
    end

    // R7: reset keeps contents
    do_reset();
    do_cmd(4'b0000, 3'd2, 13'h0084);
    wait_idle();
    h_keep = hot_sr_en;
    m_keep = ret_banks;
    do_reset();
    chk(!valid && !busy && !err, "R7 flags cleared", 16'({valid, busy, err}), 0);
    chk(ret_banks == 8'hFC && h_keep && hot_sr_en && m_keep == 8'hFC,
        "R7 contents kept", 16'({hot_sr_en, ret_banks}), 16'h01FC);

    // R6: each reserved bit
    for (int r = 3; r < 13; r++) begin
      if (r == 7) continue;
      do_reset();
      do_cmd(4'b0000, 3'd2, 13'((1 << r) | (1 << 7) | (r & 7)));
      chk(err == 1'b1, "R6 reserved bit err", 16'(err), 1);
      chk(valid && hot_sr_en && ret_banks == exp_mask(r & 7),
          "R6 fields still stored", 16'({valid, hot_sr_en, ret_banks}),
          16'({2'b11, exp_mask(r & 7)}));
      wait_idle();
    end

    // R9: err stays through a clean write
    do_cmd(4'b0000, 3'd2, 13'h0002);
    chk(err == 1'b1, "R9 err sticky", 16'(err), 1);
    chk(ret_banks == 8'h03, "R9 clean write still taken", 16'(ret_banks), 16'h03);

    done = 1'b1;
    finish_run();
  end
endmodule